// File: doc/BRIEF.md
# Low-Speed Oscillator Enable Controller

This block manages two slow clock sources: an external crystal path and an internal RC path. Software controls each path through a small write-only register set. The crystal path has an enable bit, a bypass bit and a two-bit drive-strength field. The RC path has an enable bit only. Each path counts the cycles of its oscillator after it is enabled. It raises a ready flag once the count reaches a start-up limit, and only then passes the oscillator clock to its output.

The oscillators are modelled as single-cycle pulse inputs that are synchronous to the controller clock, one pulse per oscillator period. The crystal path needs `XTAL_START` pulses to start up. The RC path needs `RC_START` pulses. In bypass mode, where a ready-made external clock is fed in, the crystal path needs only `BYP_START` pulses.

The register state guards the analog settings. While the crystal runs, the bypass selection is frozen and the drive strength can only be lowered. Each ready event sets a sticky interrupt flag. Each flag has its own enable bit and its own write-one-to-clear bit.

Top module: `lsosc_ctrl`

## Requirements
- R1: After reset, every enable, bypass, drive, interrupt-enable, ready and interrupt-flag output is 0, and both clock outputs are 0.
- R2: A write to address 0 loads bit 0 into the crystal enable. With the enable set and bypass 0, the ready flag rises at the clock edge that samples the `XTAL_START`-th oscillator pulse after the write.
- R3: With bypass (address 0 bit 1) and enable both set, the crystal ready flag rises on the `BYP_START`-th pulse instead.
- R4: A write to address 0 made while the crystal enable output is 1 leaves the bypass bit unchanged. A write made while the enable is 0 loads it.
- R5: The drive field is address 0 bits 3:2. While the crystal enable is 1, a write is accepted only if the new value is not greater than the current one. While the enable is 0, any value is accepted.
- R6: Each clock output equals its oscillator pulse input ANDed with its ready flag, so no pulse reaches an output before ready.
- R7: A write that clears an enable bit clears that path's ready flag at the same edge. The clock output is blocked from the next cycle on, and a later enable restarts the full start-up count.
- R8: A write to address 1 loads bit 0 into the RC enable. Its ready flag rises on the `RC_START`-th pulse and gates its clock output in the same way.
- R9: Interrupt flag bit 0 (crystal) and bit 1 (RC) are set by the ready rising event and then stay set. Writing 1 to the matching bit at address 3 clears a flag. A ready event in the same cycle as a clear leaves the flag set.
- R10: The interrupt enables are address 2 bits 1:0, in the same bit order as the flags. `irq_o` is the OR of the flags ANDed with their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 crystal ctrl, 1 RC ctrl, 2 irq enable, 3 irq clear) |
| wr_data_i | input | 8 | Write data |
| xtal_osc_i | input | 1 | Crystal oscillator pulse, one per period |
| rc_osc_i | input | 1 | RC oscillator pulse, one per period |
| xtal_clk_o | output | 1 | Gated crystal clock |
| rc_clk_o | output | 1 | Gated RC clock |
| xtal_on_o | output | 1 | Crystal enable state |
| xtal_byp_o | output | 1 | Crystal bypass state |
| xtal_drv_o | output | 2 | Crystal drive strength |
| rc_on_o | output | 1 | RC enable state |
| xtal_rdy_o | output | 1 | Crystal ready flag |
| rc_rdy_o | output | 1 | RC ready flag |
| irq_flag_o | output | 2 | Sticky interrupt flags |
| irq_en_o | output | 2 | Interrupt enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets the following corner cases:
- A drive write that raises the value while the crystal runs. A design that compares against the wrong value would let the drive climb.
- A bypass write made while the crystal is on. A design that ignores the guard would change the start-up length under a running oscillator.
- The exact pulse count to ready, in both normal and bypass mode. An off-by-one design would release the clock one pulse early or late.
- Clearing the enable on a ready path. A design that drops the kill term would keep ready high.
- A flag clear issued in the same cycle as a new ready event. A clear-wins design would lose that interrupt.

A long random phase compares every output with a behavioural model on every cycle.

// File: rtl/lsosc_pkg.sv
package lsosc_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int N_SRC  = 2;
  localparam int SRC_XTAL = 0;
  localparam int SRC_RC   = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_XCTL = 2'd0,
    A_RCTL = 2'd1,
    A_IEN  = 2'd2,
    A_ICLR = 2'd3
  } reg_addr_e;

  localparam int B_ON  = 0;
  localparam int B_BYP = 1;
  localparam int B_DRV = 2;

  typedef struct packed {
    logic       on;
    logic       byp;
    logic [1:0] drv;
  } xtal_cfg_t;
endpackage

// File: rtl/lsosc_regs.sv
module lsosc_regs
  import lsosc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output xtal_cfg_t         xcfg_o,
  output logic              rc_on_o,
  output logic [N_SRC-1:0]  ien_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  kill_o
);
  xtal_cfg_t        xcfg_q;
  logic             rc_on_q;
  logic [N_SRC-1:0] ien_q;
  logic             wr_x, wr_r;
  logic [1:0]       drv_new;

  assign wr_x    = wr_en_i && (wr_addr_i == A_XCTL);
  assign wr_r    = wr_en_i && (wr_addr_i == A_RCTL);
  assign drv_new = wr_data_i[B_DRV +: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcfg_q  <= '0;
      rc_on_q <= 1'b0;
      ien_q   <= '0;
    end else begin
      if (wr_x) begin
        xcfg_q.on <= wr_data_i[B_ON];
        // bypass frozen while running
        if (!xcfg_q.on) xcfg_q.byp <= wr_data_i[B_BYP];
        // drive may only stay or drop while running
        if (!xcfg_q.on || (drv_new <= xcfg_q.drv)) xcfg_q.drv <= drv_new;
      end
      if (wr_r) rc_on_q <= wr_data_i[B_ON];
      if (wr_en_i && (wr_addr_i == A_IEN)) ien_q <= wr_data_i[N_SRC-1:0];
    end
  end

  assign clr_o = (wr_en_i && (wr_addr_i == A_ICLR)) ? wr_data_i[N_SRC-1:0] : '0;
  assign kill_o[SRC_XTAL] = wr_x && xcfg_q.on && !wr_data_i[B_ON];
  assign kill_o[SRC_RC]   = wr_r && rc_on_q && !wr_data_i[B_ON];

  assign xcfg_o  = xcfg_q;
  assign rc_on_o = rc_on_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/lsosc_startup.sv
module lsosc_startup #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kill_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             rdy_o,
  output logic             set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;
  logic             run, hit;

  assign run   = en_i && !kill_i;
  assign hit   = (cnt_q == lim_i - CNT_W'(1));
  assign set_o = run && !rdy_q && tick_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (set_o) begin
      rdy_q <= 1'b1;
    end else if (!rdy_q && tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/lsosc_irq.sv
module lsosc_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_i);
endmodule

// File: rtl/lsosc_ctrl.sv
module lsosc_ctrl
  import lsosc_pkg::*;
#(
  parameter int XTAL_START = 32,
  parameter int RC_START   = 8,
  parameter int BYP_START  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       xtal_osc_i,
  input  logic       rc_osc_i,
  output logic       xtal_clk_o,
  output logic       rc_clk_o,
  output logic       xtal_on_o,
  output logic       xtal_byp_o,
  output logic [1:0] xtal_drv_o,
  output logic       rc_on_o,
  output logic       xtal_rdy_o,
  output logic       rc_rdy_o,
  output logic [1:0] irq_flag_o,
  output logic [1:0] irq_en_o,
  output logic       irq_o
);
  localparam int MAX_LIM = (XTAL_START > RC_START) ?
                           ((XTAL_START > BYP_START) ? XTAL_START : BYP_START) :
                           ((RC_START > BYP_START) ? RC_START : BYP_START);
  localparam int CNT_W = $clog2(MAX_LIM + 1);

  xtal_cfg_t        xcfg;
  logic             rc_on;
  logic [N_SRC-1:0] ien, clr, kill, en, tick, rdy, set;
  logic [CNT_W-1:0] lim [N_SRC];

  lsosc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .xcfg_o    (xcfg),
    .rc_on_o   (rc_on),
    .ien_o     (ien),
    .clr_o     (clr),
    .kill_o    (kill)
  );

  assign en[SRC_XTAL]   = xcfg.on;
  assign en[SRC_RC]     = rc_on;
  assign tick[SRC_XTAL] = xtal_osc_i;
  assign tick[SRC_RC]   = rc_osc_i;
  assign lim[SRC_XTAL]  = xcfg.byp ? CNT_W'(BYP_START) : CNT_W'(XTAL_START);
  assign lim[SRC_RC]    = CNT_W'(RC_START);

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    lsosc_startup #(.CNT_W(CNT_W)) u_start (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[s]),
      .kill_i (kill[s]),
      .tick_i (tick[s]),
      .lim_i  (lim[s]),
      .rdy_o  (rdy[s]),
      .set_o  (set[s])
    );
  end

  lsosc_irq #(.N(N_SRC)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .ien_i  (ien),
    .flag_o (irq_flag_o),
    .irq_o  (irq_o)
  );

  assign xtal_clk_o = xtal_osc_i & rdy[SRC_XTAL];
  assign rc_clk_o   = rc_osc_i & rdy[SRC_RC];
  assign xtal_on_o  = xcfg.on;
  assign xtal_byp_o = xcfg.byp;
  assign xtal_drv_o = xcfg.drv;
  assign rc_on_o    = rc_on;
  assign xtal_rdy_o = rdy[SRC_XTAL];
  assign rc_rdy_o   = rdy[SRC_RC];
  assign irq_en_o   = ien;
endmodule

// File: rtl/lsosc_ctrl_chk.sv
module lsosc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xtal_clk_o,
  input logic       rc_clk_o,
  input logic       xtal_on_o,
  input logic       xtal_byp_o,
  input logic [1:0] xtal_drv_o,
  input logic       rc_on_o,
  input logic       xtal_rdy_o,
  input logic       rc_rdy_o,
  input logic [1:0] irq_flag_o
);
  p_rdy_needs_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_rdy_o |-> xtal_on_o);

  p_byp_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_on_o |=> $stable(xtal_byp_o));

  p_drv_no_raise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_on_o |=> (xtal_drv_o <= $past(xtal_drv_o)));

  p_xtal_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtal_rdy_o |-> !xtal_clk_o);

  p_off_drops_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xtal_on_o) |-> !xtal_rdy_o);

  p_rc_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_rdy_o |-> (!rc_clk_o && (rc_on_o || !rc_rdy_o)));

  p_xtal_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xtal_rdy_o) |-> irq_flag_o[0]);

  p_rc_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rc_rdy_o) |-> irq_flag_o[1]);
endmodule

bind lsosc_ctrl lsosc_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xtal_clk_o (xtal_clk_o),
  .rc_clk_o   (rc_clk_o),
  .xtal_on_o  (xtal_on_o),
  .xtal_byp_o (xtal_byp_o),
  .xtal_drv_o (xtal_drv_o),
  .rc_on_o    (rc_on_o),
  .xtal_rdy_o (xtal_rdy_o),
  .rc_rdy_o   (rc_rdy_o),
  .irq_flag_o (irq_flag_o)
);

// File: tb/lsosc_ctrl_bench.sv
module lsosc_ctrl_bench;
  localparam int XS = 32;
  localparam int RS = 8;
  localparam int BS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       xosc = 1'b0;
  logic       rosc = 1'b0;
  logic       xtal_clk, rc_clk, xtal_on, xtal_byp, rc_on, xtal_rdy, rc_rdy, irq;
  logic [1:0] xtal_drv, irq_flag, irq_en;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  lsosc_ctrl #(.XTAL_START(XS), .RC_START(RS), .BYP_START(BS)) u_lsosc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .xtal_osc_i(xosc), .rc_osc_i(rosc),
    .xtal_clk_o(xtal_clk), .rc_clk_o(rc_clk), .xtal_on_o(xtal_on),
    .xtal_byp_o(xtal_byp), .xtal_drv_o(xtal_drv), .rc_on_o(rc_on),
    .xtal_rdy_o(xtal_rdy), .rc_rdy_o(rc_rdy), .irq_flag_o(irq_flag),
    .irq_en_o(irq_en), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_xon, m_xbyp, m_xdrv, m_ron, m_xrdy, m_rrdy, m_xcnt, m_rcnt, m_ien, m_f0, m_f1;
  int lim, d, clr;
  bit xkill, rkill, xset, rset;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_xon = 0; m_xbyp = 0; m_xdrv = 0; m_ron = 0; m_xrdy = 0; m_rrdy = 0;
      m_xcnt = 0; m_rcnt = 0; m_ien = 0; m_f0 = 0; m_f1 = 0;
    end else begin
      d = int'(wr_data);
      xkill = wr_en && wr_addr == 0 && m_xon == 1 && d % 2 == 0;
      rkill = wr_en && wr_addr == 1 && m_ron == 1 && d % 2 == 0;
      lim = (m_xbyp == 1) ? BS : XS;
      xset = m_xon == 1 && !xkill && m_xrdy == 0 && xosc && m_xcnt == lim - 1;
      rset = m_ron == 1 && !rkill && m_rrdy == 0 && rosc && m_rcnt == RS - 1;
      if (m_xon == 0 || xkill) begin m_xcnt = 0; m_xrdy = 0; end
      else if (xset) m_xrdy = 1;
      else if (m_xrdy == 0 && xosc) m_xcnt++;
      if (m_ron == 0 || rkill) begin m_rcnt = 0; m_rrdy = 0; end
      else if (rset) m_rrdy = 1;
      else if (m_rrdy == 0 && rosc) m_rcnt++;
      clr = (wr_en && wr_addr == 3) ? d % 4 : 0;
      if (xset) m_f0 = 1; else if (clr % 2 == 1) m_f0 = 0;
      if (rset) m_f1 = 1; else if (clr / 2 == 1) m_f1 = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            if (m_xon == 0) m_xbyp = (d / 2) % 2;
            if (m_xon == 0 || (d / 4) % 4 <= m_xdrv) m_xdrv = (d / 4) % 4;
            m_xon = d % 2;
          end
          2'd1: m_ron = d % 2;
          2'd2: m_ien = d % 4;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "xtal_on", xtal_on, m_xon);
      chk("R2", "xtal_rdy", xtal_rdy, m_xrdy);
      chk("R4", "xtal_byp", xtal_byp, m_xbyp);
      chk("R5", "xtal_drv", xtal_drv, m_xdrv);
      chk("R6", "xtal_clk", xtal_clk, (xosc && m_xrdy == 1) ? 1 : 0);
      chk("R8", "rc_on", rc_on, m_ron);
      chk("R8", "rc_rdy", rc_rdy, m_rrdy);
      chk("R8", "rc_clk", rc_clk, (rosc && m_rrdy == 1) ? 1 : 0);
      chk("R9", "irq_flag", irq_flag, m_f1 * 2 + m_f0);
      chk("R10", "irq_en", irq_en, m_ien);
      chk("R10", "irq", irq, ((m_f1 * 2 + m_f0) & m_ien) != 0 ? 1 : 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    xosc = 1'b0;
    rosc = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset state", {xtal_on, xtal_byp, xtal_drv, rc_on, xtal_rdy, rc_rdy,
        irq_flag, irq_en, irq, xtal_clk, rc_clk}, 0);
    tick();

    wr(2, 8'h03);
    wr(0, 8'b0000_1101);                 // on, drive 3
    for (int k = 0; k < XS - 1; k++) begin
      xosc = 1'b1;
      @(negedge clk);
      if (k == 0) chk("R6", "clk before ready", xtal_clk, 0);
      tick();
    end
    @(negedge clk);
    chk("R2", "rdy one pulse early", xtal_rdy, 0);
    xosc = 1'b1;
    tick();
    xosc = 1'b1;
    @(negedge clk);
    chk("R2", "rdy on last pulse", xtal_rdy, 1);
    chk("R6", "clk passes", xtal_clk, 1);
    chk("R9", "xtal flag", irq_flag[0], 1);
    chk("R10", "irq asserted", irq, 1);
    tick();

    wr(0, 8'b0000_0101);
    @(negedge clk); chk("R5", "drive lowered", xtal_drv, 1);
    wr(0, 8'b0000_1101);
    @(negedge clk); chk("R5", "drive raise rejected", xtal_drv, 1);
    wr(0, 8'b0000_0011);
    @(negedge clk);
    chk("R4", "bypass ignored while on", xtal_byp, 0);
    chk("R5", "drive to lowest", xtal_drv, 0);
    wr(3, 8'h01);
    @(negedge clk);
    chk("R9", "flag cleared", irq_flag[0], 0);
    chk("R10", "irq dropped", irq, 0);

    wr(0, 8'h00);
    xosc = 1'b1;
    @(negedge clk);
    chk("R7", "rdy cleared by off", xtal_rdy, 0);
    chk("R7", "clk blocked after off", xtal_clk, 0);
    tick();

    wr(0, 8'b0000_1110);
    @(negedge clk);
    chk("R4", "bypass loaded while off", xtal_byp, 1);
    chk("R5", "drive free while off", xtal_drv, 3);
    wr(0, 8'b0000_1111);
    for (int k = 0; k < BS - 1; k++) begin xosc = 1'b1; tick(); end
    @(negedge clk); chk("R3", "bypass rdy early", xtal_rdy, 0);
    xosc = 1'b1; tick();
    @(negedge clk); chk("R3", "bypass rdy", xtal_rdy, 1);
    wr(0, 8'h00);
    wr(0, 8'h00);

    wr(1, 8'h01);
    for (int k = 0; k < RS; k++) begin rosc = 1'b1; tick(); end
    @(negedge clk);
    chk("R8", "rc rdy", rc_rdy, 1);
    chk("R9", "rc flag", irq_flag[1], 1);
    wr(1, 8'h00);
    @(negedge clk); chk("R7", "rc rdy cleared", rc_rdy, 0);
    wr(3, 8'h02);
    @(negedge clk); chk("R9", "rc flag cleared", irq_flag[1], 0);
    wr(1, 8'h01);
    for (int k = 0; k < RS - 1; k++) begin rosc = 1'b1; tick(); end
    rosc = 1'b1;
    wr(3, 8'h02);                        // clear coincides with ready
    @(negedge clk);
    chk("R9", "set beats clear", irq_flag[1], 1);
    chk("R8", "rc rdy again", rc_rdy, 1);

    for (int n = 0; n < 4000; n++) begin
      xosc = ($urandom % 3) == 0;
      rosc = ($urandom % 2) == 0;
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1;
        wr_addr = 2'($urandom % 4);
        wr_data = 8'($urandom % 16);
      end
      tick();
    end
    finish_run();
  end
endmodule